// File: doc/BRIEF.md
# Scan-Port Flash Frame Loader

This block is a boundary-scan test access port with a small set of private instructions. A host uses them to stream flash images into a chip. The port follows the standard sixteen-state controller on `tck`/`tms` and holds a 4-bit instruction register.

The instructions do the following:
- An identification instruction returns a fixed 32-bit device code on the serial output.
- Two strobe instructions, erase and program, each deliver a single-cycle request to a flash-programming controller. That controller runs on the system clock.
- A frame-load instruction packs serial input bits into 32-bit words. It writes them through a simple write port into a one-frame buffer of 4096 bits (128 words). The programming controller later copies that buffer into flash.

The serial output value changes on the falling edge of `tck`. It is accompanied by a pad output-enable that is asserted only while a shift state is active. The requests cross into the system clock domain through toggle synchronizers. Flash timing and address generation belong to the downstream controller and are not part of this block.

Top module: `jtag_frame_loader`

## Requirements
- R1: The controller implements the standard sixteen-state graph, advancing on each rising edge of `tck` from `tms`. Five consecutive rising edges with `tms` high reach Test-Logic-Reset from any state, and that state selects the identification instruction.
- R2: After `tapRstN` is asserted, `tdoOe`, `bufWrEn`, `eraseStrobe` and `programStrobe` are low, and the identification instruction is active without any instruction scan.
- R3: Capture-IR loads the pattern 4'b0001, which is shifted out least significant bit first on `tdo` during Shift-IR.
- R4: Opcode 4'b0010 selects a 32-bit data register that captures `ID_VALUE` and shifts it out least significant bit first.
- R5: Every opcode other than 4'b0010 selects a one-bit data register that captures 0 and then presents each `tdi` bit on `tdo` one shift later. This applies to the unassigned codes and to 4'b0011, 4'b0100 and 4'b0101.
- R6: Entering Update-IR with opcode 4'b0011 produces exactly one `sysClk`-cycle pulse on `eraseStrobe` and none on `programStrobe`.
- R7: Entering Update-IR with opcode 4'b0101 produces exactly one `sysClk`-cycle pulse on `programStrobe` and none on `eraseStrobe`.
- R8: Instruction updates with any other opcode, and all data scans, produce no strobe pulses. A repeated erase update produces another pulse.
- R9: With opcode 4'b0100, Shift-DR bits are packed least significant bit first into 32-bit words. Word k is written at address k with a one-`tck`-cycle `bufWrEn` pulse, giving 128 writes for a 4096-bit frame.
- R10: The write address returns to 0 at every Capture-DR, and a trailing partial word of fewer than 32 bits is never written.
- R11: `tdoOe` is high exactly while the controller is in Shift-IR or Shift-DR, and both `tdo` and `tdoOe` update on the falling edge of `tck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Scan clock |
| tapRstN | input | 1 | Asynchronous scan reset, active low |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdoOe | output | 1 | Pad enable for `tdo`; pad floats when low |
| sysClk | input | 1 | System clock of the programming controller |
| sysRstN | input | 1 | Asynchronous system reset, active low |
| eraseStrobe | output | 1 | One-cycle erase request, `sysClk` domain |
| programStrobe | output | 1 | One-cycle program request, `sysClk` domain |
| bufWrEn | output | 1 | Frame buffer write enable, `tck` domain |
| bufWrAddr | output | 7 | Frame buffer word address |
| bufWrData | output | 32 | Frame buffer write word |

## Verification
All twelve unassigned opcodes are swept with a distinct 8-bit serial pattern each. This separates a one-shift echo from a stuck output, from a wrong capture value and from a leak into the identification register. A full 4096-bit frame built from an arithmetic word sequence exposes bit-order, word-boundary and address-ordering faults. The erase, program and neutral instruction updates are counted pulse by pulse, which distinguishes missing, duplicated and swapped requests. A 40-bit scan followed by a 32-bit scan checks that partial words are dropped and that the address restarts. A forced reset from Pause-DR shows the five-cycle reset path.

// File: rtl/jfl_pkg.sv
package jfl_pkg;

  localparam int IR_W = 4;

  localparam logic [IR_W-1:0] OP_IDCODE  = 4'b0010;
  localparam logic [IR_W-1:0] OP_ERASE   = 4'b0011;
  localparam logic [IR_W-1:0] OP_LOAD    = 4'b0100;
  localparam logic [IR_W-1:0] OP_PROGRAM = 4'b0101;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

  typedef enum logic [3:0] {
    TAP_RESET    = 4'h0,
    TAP_IDLE     = 4'h1,
    TAP_SEL_DR   = 4'h2,
    TAP_CAP_DR   = 4'h3,
    TAP_SHIFT_DR = 4'h4,
    TAP_EXIT1_DR = 4'h5,
    TAP_PAUSE_DR = 4'h6,
    TAP_EXIT2_DR = 4'h7,
    TAP_UPD_DR   = 4'h8,
    TAP_SEL_IR   = 4'h9,
    TAP_CAP_IR   = 4'hA,
    TAP_SHIFT_IR = 4'hB,
    TAP_EXIT1_IR = 4'hC,
    TAP_PAUSE_IR = 4'hD,
    TAP_EXIT2_IR = 4'hE,
    TAP_UPD_IR   = 4'hF
  } tapState_e;

  // strobes from the control half to the datapath half
  typedef struct packed {
    logic captureDr;
    logic shiftDr;
    logic shiftIr;
    logic selId;
    logic selLoad;
  } tapCtrl_t;

endpackage

// File: rtl/jfl_tap_ctrl.sv
module jfl_tap_ctrl
  import jfl_pkg::*;
(
  input  logic     tck,
  input  logic     tapRstN,
  input  logic     tms,
  input  logic     tdi,
  output tapCtrl_t ctrl,
  output logic     irLsb,
  output logic     tapInReset,
  output logic     eraseTgl,
  output logic     programTgl
);

  tapState_e        state, nextState;
  logic [IR_W-1:0]  irShift;
  logic [IR_W-1:0]  irReg;

  always_comb begin
    case (state)
      TAP_RESET:    nextState = tms ? TAP_RESET    : TAP_IDLE;
      TAP_IDLE:     nextState = tms ? TAP_SEL_DR   : TAP_IDLE;
      TAP_SEL_DR:   nextState = tms ? TAP_SEL_IR   : TAP_CAP_DR;
      TAP_CAP_DR:   nextState = tms ? TAP_EXIT1_DR : TAP_SHIFT_DR;
      TAP_SHIFT_DR: nextState = tms ? TAP_EXIT1_DR : TAP_SHIFT_DR;
      TAP_EXIT1_DR: nextState = tms ? TAP_UPD_DR   : TAP_PAUSE_DR;
      TAP_PAUSE_DR: nextState = tms ? TAP_EXIT2_DR : TAP_PAUSE_DR;
      TAP_EXIT2_DR: nextState = tms ? TAP_UPD_DR   : TAP_SHIFT_DR;
      TAP_UPD_DR:   nextState = tms ? TAP_SEL_DR   : TAP_IDLE;
      TAP_SEL_IR:   nextState = tms ? TAP_RESET    : TAP_CAP_IR;
      TAP_CAP_IR:   nextState = tms ? TAP_EXIT1_IR : TAP_SHIFT_IR;
      TAP_SHIFT_IR: nextState = tms ? TAP_EXIT1_IR : TAP_SHIFT_IR;
      TAP_EXIT1_IR: nextState = tms ? TAP_UPD_IR   : TAP_PAUSE_IR;
      TAP_PAUSE_IR: nextState = tms ? TAP_EXIT2_IR : TAP_PAUSE_IR;
      TAP_EXIT2_IR: nextState = tms ? TAP_UPD_IR   : TAP_SHIFT_IR;
      TAP_UPD_IR:   nextState = tms ? TAP_SEL_DR   : TAP_IDLE;
      default:      nextState = TAP_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge tapRstN) begin
    if (!tapRstN) state <= TAP_RESET;
    else          state <= nextState;
  end

  // instruction shift path, LSB leaves first
  always_ff @(posedge tck or negedge tapRstN) begin
    if (!tapRstN)                  irShift <= IR_CAPTURE;
    else if (state == TAP_CAP_IR)  irShift <= IR_CAPTURE;
    else if (state == TAP_SHIFT_IR) irShift <= {tdi, irShift[IR_W-1:1]};
  end

  // active instruction and request toggles, taken on entry to Update-IR
  always_ff @(posedge tck or negedge tapRstN) begin
    if (!tapRstN) begin
      irReg      <= OP_IDCODE;
      eraseTgl   <= 1'b0;
      programTgl <= 1'b0;
    end else if (state == TAP_RESET) begin
      irReg <= OP_IDCODE;
    end else if (nextState == TAP_UPD_IR) begin
      irReg <= irShift;
      if (irShift == OP_ERASE)   eraseTgl   <= ~eraseTgl;
      if (irShift == OP_PROGRAM) programTgl <= ~programTgl;
    end
  end

  always_comb begin
    ctrl.captureDr = (state == TAP_CAP_DR);
    ctrl.shiftDr   = (state == TAP_SHIFT_DR);
    ctrl.shiftIr   = (state == TAP_SHIFT_IR);
    ctrl.selId     = (irReg == OP_IDCODE);
    ctrl.selLoad   = (irReg == OP_LOAD);
  end

  assign irLsb      = irShift[0];
  assign tapInReset = (state == TAP_RESET);

endmodule

// File: rtl/jfl_datapath.sv
module jfl_datapath
  import jfl_pkg::*;
#(
  parameter logic [31:0] ID_VALUE = 32'h1A2B_3C4D,
  parameter int          WORD_W   = 32,
  parameter int          ADDR_W   = 7
)(
  input  logic              tck,
  input  logic              tapRstN,
  input  logic              tdi,
  input  tapCtrl_t          ctrl,
  input  logic              irLsb,
  output logic              tdo,
  output logic              tdoOe,
  output logic              bufWrEn,
  output logic [ADDR_W-1:0] bufWrAddr,
  output logic [WORD_W-1:0] bufWrData
);

  localparam int               CNT_W    = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic [31:0]        idShift;
  logic               bypassBit;
  logic [WORD_W-2:0]  wordShift;
  logic [CNT_W-1:0]   bitCnt;
  logic [ADDR_W-1:0]  wordAddr;

  // identification register
  always_ff @(posedge tck or negedge tapRstN) begin
    if (!tapRstN)           idShift <= ID_VALUE;
    else if (ctrl.captureDr) idShift <= ID_VALUE;
    else if (ctrl.shiftDr)   idShift <= {tdi, idShift[31:1]};
  end

  // one-bit register serving every non-ID instruction
  always_ff @(posedge tck or negedge tapRstN) begin
    if (!tapRstN)           bypassBit <= 1'b0;
    else if (ctrl.captureDr) bypassBit <= 1'b0;
    else if (ctrl.shiftDr)   bypassBit <= tdi;
  end

  // frame packer: LSB-first words, one write per full word
  always_ff @(posedge tck or negedge tapRstN) begin
    if (!tapRstN) begin
      wordShift <= '0;
      bitCnt    <= '0;
      wordAddr  <= '0;
      bufWrEn   <= 1'b0;
      bufWrAddr <= '0;
      bufWrData <= '0;
    end else begin
      bufWrEn <= 1'b0;
      if (ctrl.captureDr) begin
        bitCnt   <= '0;
        wordAddr <= '0;
      end else if (ctrl.shiftDr && ctrl.selLoad) begin
        wordShift <= {tdi, wordShift[WORD_W-2:1]};
        if (bitCnt == LAST_BIT) begin
          bitCnt    <= '0;
          bufWrEn   <= 1'b1;
          bufWrAddr <= wordAddr;
          bufWrData <= {tdi, wordShift};
          wordAddr  <= wordAddr + 1'b1;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  // serial output launched on the falling edge
  always_ff @(negedge tck or negedge tapRstN) begin
    if (!tapRstN) begin
      tdo   <= 1'b0;
      tdoOe <= 1'b0;
    end else begin
      tdoOe <= ctrl.shiftIr | ctrl.shiftDr;
      if (ctrl.shiftIr)    tdo <= irLsb;
      else if (ctrl.selId) tdo <= idShift[0];
      else                 tdo <= bypassBit;
    end
  end

endmodule

// File: rtl/jfl_toggle_sync.sv
module jfl_toggle_sync (
  input  logic sysClk,
  input  logic sysRstN,
  input  logic tglIn,
  output logic pulse
);

  logic [2:0] syncQ;

  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN) syncQ <= '0;
    else          syncQ <= {syncQ[1:0], tglIn};
  end

  assign pulse = syncQ[2] ^ syncQ[1];

endmodule

// File: rtl/jtag_frame_loader.sv
module jtag_frame_loader
  import jfl_pkg::*;
#(
  parameter logic [31:0] ID_VALUE   = 32'h1A2B_3C4D,
  parameter int          FRAME_BITS = 4096,
  parameter int          WORD_W     = 32,
  localparam int         FRAME_WORDS = FRAME_BITS / WORD_W,
  localparam int         ADDR_W      = $clog2(FRAME_WORDS)
)(
  input  logic              tck,
  input  logic              tapRstN,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic              tdoOe,
  input  logic              sysClk,
  input  logic              sysRstN,
  output logic              eraseStrobe,
  output logic              programStrobe,
  output logic              bufWrEn,
  output logic [ADDR_W-1:0] bufWrAddr,
  output logic [WORD_W-1:0] bufWrData
);

  localparam int NUM_REQ = 2;

  tapCtrl_t           ctrlBus;
  logic               irLsb;
  logic               tapInReset;
  logic [NUM_REQ-1:0] tglBus;
  logic [NUM_REQ-1:0] strobeBus;

  jfl_tap_ctrl u_ctrl (
    .tck        (tck),
    .tapRstN    (tapRstN),
    .tms        (tms),
    .tdi        (tdi),
    .ctrl       (ctrlBus),
    .irLsb      (irLsb),
    .tapInReset (tapInReset),
    .eraseTgl   (tglBus[0]),
    .programTgl (tglBus[1])
  );

  jfl_datapath #(
    .ID_VALUE (ID_VALUE),
    .WORD_W   (WORD_W),
    .ADDR_W   (ADDR_W)
  ) u_dp (
    .tck       (tck),
    .tapRstN   (tapRstN),
    .tdi       (tdi),
    .ctrl      (ctrlBus),
    .irLsb     (irLsb),
    .tdo       (tdo),
    .tdoOe     (tdoOe),
    .bufWrEn   (bufWrEn),
    .bufWrAddr (bufWrAddr),
    .bufWrData (bufWrData)
  );

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
    jfl_toggle_sync u_sync (
      .sysClk  (sysClk),
      .sysRstN (sysRstN),
      .tglIn   (tglBus[g]),
      .pulse   (strobeBus[g])
    );
  end

  assign eraseStrobe   = strobeBus[0];
  assign programStrobe = strobeBus[1];

endmodule

// File: rtl/jtag_frame_loader_chk.sv
module jtag_frame_loader_chk
  import jfl_pkg::*;
(
  input logic     tck,
  input logic     tapRstN,
  input logic     tms,
  input logic     tdoOe,
  input logic     sysClk,
  input logic     sysRstN,
  input logic     eraseStrobe,
  input logic     programStrobe,
  input logic     bufWrEn,
  input tapCtrl_t ctrlBus,
  input logic     tapInReset
);

  logic [2:0] tmsHighRun;

  always_ff @(posedge tck or negedge tapRstN) begin
    if (!tapRstN)               tmsHighRun <= '0;
    else if (!tms)              tmsHighRun <= '0;
    else if (tmsHighRun != 3'd5) tmsHighRun <= tmsHighRun + 3'd1;
  end

  // R1
  five_high_reset_chk: assert property (@(posedge tck) disable iff (!tapRstN)
    (tmsHighRun == 3'd5) |-> tapInReset);

  // R11
  oe_off_outside_shift_chk: assert property (@(posedge tck) disable iff (!tapRstN)
    !(ctrlBus.shiftIr || ctrlBus.shiftDr) |-> !tdoOe);

  // R11
  oe_on_in_shift_chk: assert property (@(posedge tck) disable iff (!tapRstN)
    (ctrlBus.shiftIr || ctrlBus.shiftDr) |-> tdoOe);

  // R9
  single_write_pulse_chk: assert property (@(posedge tck) disable iff (!tapRstN)
    bufWrEn |=> !bufWrEn);

  // R9
  write_follows_load_shift_chk: assert property (@(posedge tck) disable iff (!tapRstN)
    bufWrEn |-> $past(ctrlBus.shiftDr && ctrlBus.selLoad));

  // R10
  no_write_after_capture_chk: assert property (@(posedge tck) disable iff (!tapRstN)
    ctrlBus.captureDr |=> !bufWrEn);

  // R5
  decode_exclusive_chk: assert property (@(posedge tck) disable iff (!tapRstN)
    $onehot0({ctrlBus.selId, ctrlBus.selLoad}));

  // R6
  erase_single_cycle_chk: assert property (@(posedge sysClk) disable iff (!sysRstN)
    eraseStrobe |=> !eraseStrobe);

  // R7
  program_single_cycle_chk: assert property (@(posedge sysClk) disable iff (!sysRstN)
    programStrobe |=> !programStrobe);

  // R8
  strobes_exclusive_chk: assert property (@(posedge sysClk) disable iff (!sysRstN)
    !(eraseStrobe && programStrobe));

endmodule

bind jtag_frame_loader jtag_frame_loader_chk u_chk (
  .tck           (tck),
  .tapRstN       (tapRstN),
  .tms           (tms),
  .tdoOe         (tdoOe),
  .sysClk        (sysClk),
  .sysRstN       (sysRstN),
  .eraseStrobe   (eraseStrobe),
  .programStrobe (programStrobe),
  .bufWrEn       (bufWrEn),
  .ctrlBus       (ctrlBus),
  .tapInReset    (tapInReset)
);

// File: tb/jtag_frame_loader_bench.sv
`timescale 1ns/1ps
module jtag_frame_loader_bench;

  localparam logic [31:0] ID_VALUE = 32'h1A2B_3C4D;
  localparam int FRAME_BITS = 4096;
  localparam int WORD_W = 32;
  localparam int FRAME_WORDS = FRAME_BITS / WORD_W;

  logic tck = 1'b0, tapRstN = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic sysClk = 1'b0, sysRstN = 1'b0;
  logic tdo, tdoOe, eraseStrobe, programStrobe, bufWrEn;
  logic [6:0]  bufWrAddr;
  logic [31:0] bufWrData;

  int checks = 0, errors = 0;
  int eraseCnt = 0, programCnt = 0, wrCount = 0;
  logic [31:0] wrData [0:255];
  logic [6:0]  wrAddr [0:255];
  bit done = 0;

  always #10 sysClk = ~sysClk;

  jtag_frame_loader #(.ID_VALUE(ID_VALUE), .FRAME_BITS(FRAME_BITS), .WORD_W(WORD_W)) u_jtag_frame_loader (
    .tck(tck), .tapRstN(tapRstN), .tms(tms), .tdi(tdi), .tdo(tdo), .tdoOe(tdoOe),
    .sysClk(sysClk), .sysRstN(sysRstN), .eraseStrobe(eraseStrobe),
    .programStrobe(programStrobe), .bufWrEn(bufWrEn), .bufWrAddr(bufWrAddr),
    .bufWrData(bufWrData));

  always @(negedge sysClk) begin
    if (eraseStrobe === 1'b1)   eraseCnt++;
    if (programStrobe === 1'b1) programCnt++;
  end

  always @(negedge tck) begin
    if (bufWrEn === 1'b1) begin
      if (wrCount < 256) begin
        wrData[wrCount] = bufWrData;
        wrAddr[wrCount] = bufWrAddr;
      end
      wrCount++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // one TCK period: inputs set while low, tdo sampled after the falling edge
  task automatic tckCycle(input logic tmsV, input logic tdiV, output logic tdoV);
    tms = tmsV; tdi = tdiV;
    #15 tck = 1'b1;
    #15 tck = 1'b0;
    #10 tdoV = tdo;
    #20;
  endtask

  task automatic tapReset();
    logic t;
    for (int i = 0; i < 5; i++) tckCycle(1'b1, 1'b0, t);
    tckCycle(1'b0, 1'b0, t);
  endtask

  task automatic loadIr(input logic [3:0] op, output logic [3:0] cap);
    logic t;
    tckCycle(1'b1, 1'b0, t);
    tckCycle(1'b1, 1'b0, t);
    tckCycle(1'b0, 1'b0, t);
    tckCycle(1'b0, 1'b0, t); cap[0] = t;
    for (int i = 0; i < 4; i++) begin
      tckCycle(i == 3, op[i], t);
      if (i < 3) cap[i+1] = t;
    end
    tckCycle(1'b1, 1'b0, t);
    tckCycle(1'b0, 1'b0, t);
  endtask

  task automatic scanDr(input int n, input logic [63:0] din, output logic [63:0] dout, output logic oeExit);
    logic t;
    dout = '0;
    tckCycle(1'b1, 1'b0, t);
    tckCycle(1'b0, 1'b0, t);
    tckCycle(1'b0, 1'b0, t); dout[0] = t;
    for (int i = 0; i < n; i++) begin
      tckCycle(i == n-1, din[i], t);
      if (i < n-1) dout[i+1] = t;
      else oeExit = tdoOe;
    end
    tckCycle(1'b1, 1'b0, t);
    tckCycle(1'b0, 1'b0, t);
  endtask

  function automatic logic [31:0] frameWord(input int k, input int seed);
    return (32'(k) * 32'h9E37_79B9) ^ 32'(seed) ^ {16'(k), 16'hA5C3};
  endfunction

  task automatic scanLoad(input int nBits, input int seed, output int echoErr);
    logic t, b, prev;
    logic [31:0] w;
    echoErr = 0;
    tckCycle(1'b1, 1'b0, t);
    tckCycle(1'b0, 1'b0, t);
    tckCycle(1'b0, 1'b0, t);
    if (t !== 1'b0) echoErr++;
    for (int i = 0; i < nBits; i++) begin
      w = frameWord(i / 32, seed);
      b = w[i % 32];
      tckCycle(i == nBits-1, b, t);
      if (i < nBits-1 && t !== b) echoErr++;
      prev = b;
    end
    if (prev === 1'bx) echoErr++;
    tckCycle(1'b1, 1'b0, t);
    tckCycle(1'b0, 1'b0, t);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] cap;
    logic [63:0] dout;
    logic oe;
    int e0, p0, echoErr, bad;
    logic [7:0] pat;

    #95;
    // R2 reset state
    check(tdoOe === 1'b0 && bufWrEn === 1'b0 && eraseStrobe === 1'b0 && programStrobe === 1'b0,
          "R2 reset outputs", {tdoOe, bufWrEn, eraseStrobe, programStrobe}, 0);
    tapRstN = 1'b1; sysRstN = 1'b1;
    #100;
    tapReset();

    // R2 / R4: ID without instruction scan, R11 enable off at exit
    scanDr(32, 64'h0, dout, oe);
    check(dout[31:0] === ID_VALUE, "R2 default instruction reads ID", dout[31:0], ID_VALUE);
    check(oe === 1'b0, "R11 enable low after Shift-DR exit", oe, 0);

    // R3 capture pattern, R4 explicit ID
    loadIr(4'b0010, cap);
    check(cap === 4'b0001, "R3 IR capture pattern", cap, 4'b0001);
    scanDr(32, 64'hFFFF_FFFF, dout, oe);
    check(dout[31:0] === ID_VALUE, "R4 ID register", dout[31:0], ID_VALUE);

    // R5 sweep over unassigned opcodes, R8 no strobes from them
    e0 = eraseCnt; p0 = programCnt;
    for (int op = 0; op < 16; op++) begin
      if (op >= 2 && op <= 5) continue;
      loadIr(4'(op), cap);
      pat = 8'(op * 37 + 90);
      scanDr(8, {56'h0, pat}, dout, oe);
      check(dout[7:0] === {pat[6:0], 1'b0}, $sformatf("R5 bypass op %0d", op), dout[7:0], {pat[6:0], 1'b0});
    end
    #200;
    check(eraseCnt == e0 && programCnt == p0, "R8 no strobe from other opcodes", {eraseCnt, programCnt}, {e0, p0});

    // R6 erase
    e0 = eraseCnt; p0 = programCnt;
    loadIr(4'b0011, cap);
    #200;
    check(eraseCnt == e0 + 1 && programCnt == p0, "R6 erase request", {eraseCnt, programCnt}, {e0 + 1, p0});
    scanDr(8, 64'hA5, dout, oe);
    check(dout[7:0] === 8'h4A, "R5 erase selects bypass", dout[7:0], 8'h4A);

    // R7 program
    e0 = eraseCnt; p0 = programCnt;
    loadIr(4'b0101, cap);
    #200;
    check(programCnt == p0 + 1 && eraseCnt == e0, "R7 program request", {eraseCnt, programCnt}, {e0, p0 + 1});

    // R8 repeated erase
    e0 = eraseCnt;
    loadIr(4'b0011, cap);
    #200;
    check(eraseCnt == e0 + 1, "R8 repeated erase", eraseCnt, e0 + 1);

    // R1 forced reset from Pause-DR restores ID
    loadIr(4'b1111, cap);
    tckCycle(1'b1, 1'b0, oe);
    tckCycle(1'b0, 1'b0, oe);
    tckCycle(1'b1, 1'b0, oe);
    tckCycle(1'b0, 1'b0, oe);
    tapReset();
    scanDr(32, 64'h0, dout, oe);
    check(dout[31:0] === ID_VALUE, "R1 five TMS high reach reset", dout[31:0], ID_VALUE);

    // R9 full frame
    e0 = eraseCnt; p0 = programCnt;
    loadIr(4'b0100, cap);
    wrCount = 0;
    scanLoad(FRAME_BITS, 32'h0BAD_F00D, echoErr);
    check(wrCount == FRAME_WORDS, "R9 writes per frame", wrCount, FRAME_WORDS);
    bad = 0;
    for (int k = 0; k < FRAME_WORDS; k++)
      if (wrAddr[k] !== 7'(k) || wrData[k] !== frameWord(k, 32'h0BAD_F00D)) bad++;
    check(bad == 0, "R9 frame words and addresses", bad, 0);
    check(echoErr == 0, "R5 load echoes TDI one shift late", echoErr, 0);

    // R10 partial word dropped, address restarts
    wrCount = 0;
    scanLoad(40, 32'h1357_9BDF, echoErr);
    check(wrCount == 1 && wrAddr[0] === 7'd0 && wrData[0] === frameWord(0, 32'h1357_9BDF),
          "R10 partial word dropped", {32'(wrCount), wrData[0]}, {32'd1, frameWord(0, 32'h1357_9BDF)});
    scanLoad(32, 32'h2468_ACE0, echoErr);
    check(wrCount == 2 && wrAddr[1] === 7'd0 && wrData[1] === frameWord(0, 32'h2468_ACE0),
          "R10 address restarts", {25'(wrCount), wrAddr[1], wrData[1]}, {25'd2, 7'd0, frameWord(0, 32'h2468_ACE0)});
    #200;
    check(eraseCnt == e0 && programCnt == p0, "R8 no strobe from load scans", {eraseCnt, programCnt}, {e0, p0});

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule